// File: doc/BRIEF.md
# Half-Step Prescaled Baud Enable Generator

This block derives the sampling and shift timing for a serial transmitter and receiver from the system clock. It runs everything on a single rising-edge clock and outputs single-cycle enable pulses. The clock is divided in two stages. The first stage is a prescaler whose factor moves in half steps from 1 to 16. The second stage is an 11-bit counter that produces the x16 oversampling enable. A final divide by 16 gives the bit-rate enable.

Software programs the rate through two byte-wide registers on a one-bit-address register bus. The prescaler register holds a 5-bit prescaler code in bits [7:3] and the upper three bits of the 11-bit divisor in bits [2:0]. The baud register holds divisor bits [7:0].

A prescaler code of zero stops all enable generation as a power-down state. Reset puts the block in that state. The transmit side and the receive side can each take their x16 timing from an external clock pin instead of the internal chain.

Top module: `baud_clk_gen`

## Requirements
- R1: Prescaler code s (1..31) divides the system clock by an average of (s+1)/2. Periods alternate between the floor and ceiling lengths, so two consecutive prescaler periods always total s+1 cycles. With s >= 3, no two prescaler pulses are adjacent.
- R2: The divisor is D = {prescaler register [2:0], baud register [7:0]}, and the second stage divides by D+1. On internal timing, the 1st and 3rd x16 enables after a reload are exactly (D+1)*(s+1) cycles apart. This holds up to D = 2047.
- R3: While the prescaler code is 0, all four enable outputs stay low. This includes a channel set to the external pin while that pin toggles.
- R4: Address 0 reads back the prescaler register and address 1 reads back the baud register. The read data is combinational from the address.
- R5: After reset both registers read 0 and no enable is produced.
- R6: Each bit enable coincides with an x16 enable of the same channel and occurs on every 16th one. Consecutive bit enables on internal timing are 8*(D+1)*(s+1) cycles apart.
- R7: With its select high, a channel produces one x16 enable for each rising edge of the external pin, after a two-flop synchroniser. The other channel keeps its own source.
- R8: A write to either register reloads both divider stages and both bit counters. If the write is captured at clock edge e, the first internal x16 enable is visible 2 + ceil((D+1)*(s+1)/2) cycles after e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = prescaler register, 1 = baud register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| tx_src_ext | input | 1 | Transmit channel uses the external pin when high |
| rx_src_ext | input | 1 | Receive channel uses the external pin when high |
| ext_clk_in | input | 1 | External clock pin, asynchronous |
| tx_x16_en | output | 1 | Transmit x16 oversampling enable |
| rx_x16_en | output | 1 | Receive x16 oversampling enable |
| tx_bit_en | output | 1 | Transmit bit-rate enable |
| rx_bit_en | output | 1 | Receive bit-rate enable |

## Verification
The bench builds the block with its default parameters: a 5-bit prescaler code, an 11-bit divisor, 16x oversampling and a two-stage synchroniser. With these values every odd and even prescaler code can be reached. The full 2047 divisor can be reached at the fastest prescaler setting, and bit periods stay short enough to measure many random rates. Because half-step factors make single periods uneven, the bench compares spans of two x16 periods, which are exact integers. It also times the first enable after a reload.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
   localparam int unsigned CHAN_N   = 2;
   localparam int unsigned CHAN_TX  = 0;
   localparam int unsigned CHAN_RX  = 1;
   typedef enum logic {ADDR_PSC = 1'b0, ADDR_BAUD = 1'b1} reg_addr_e;
endpackage

// File: rtl/baud_psc_frac.sv
// First stage: half-step prescaler, factor (code+1)/2, built as a step-2 accumulator.
module baud_psc_frac #(
   parameter int unsigned PSC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload,
   input  logic [PSC_W-1:0] code,
   output logic             tick
);
   localparam int unsigned ACC_W = PSC_W + 2;

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] nxt;
   logic [ACC_W-1:0] modulus;

   assign modulus = ACC_W'(code) + ACC_W'(1);
   assign nxt     = acc + ACC_W'(2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         tick <= 1'b0;
      end else if (reload || code == '0) begin
         acc  <= '0;
         tick <= 1'b0;
      end else if (nxt >= modulus) begin
         acc  <= nxt - modulus;
         tick <= 1'b1;
      end else begin
         acc  <= nxt;
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/baud_div_cnt.sv
// Second stage: divide prescaler ticks by div+1.
module baud_div_cnt #(
   parameter int unsigned DIV_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload,
   input  logic [DIV_W-1:0] div,
   input  logic             in_tick,
   output logic             out_tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         out_tick <= 1'b0;
      end else if (reload) begin
         cnt      <= div;
         out_tick <= 1'b0;
      end else if (in_tick) begin
         if (cnt == '0) begin
            cnt      <= div;
            out_tick <= 1'b1;
         end else begin
            cnt      <= cnt - DIV_W'(1);
            out_tick <= 1'b0;
         end
      end else begin
         out_tick <= 1'b0;
      end
   end
endmodule

// File: rtl/baud_ext_sync.sv
// External pin: synchroniser chain plus rising-edge detect.
module baud_ext_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise
);
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], pin};
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/baud_chan_sel.sv
// Per-channel source select, power-down gate and oversampling divide.
module baud_chan_sel #(
   parameter int unsigned OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload,
   input  logic run,
   input  logic use_ext,
   input  logic int_tick,
   input  logic ext_tick,
   output logic x16_en,
   output logic bit_en
);
   localparam int unsigned OC_W = (OVS > 1) ? $clog2(OVS) : 1;
   localparam logic [OC_W-1:0] OC_LAST = OC_W'(OVS - 1);

   logic [OC_W-1:0] ocnt;

   assign x16_en = run & (use_ext ? ext_tick : int_tick);
   assign bit_en = x16_en & (ocnt == OC_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ocnt <= '0;
      else if (reload) ocnt <= '0;
      else if (x16_en) ocnt <= (ocnt == OC_LAST) ? '0 : ocnt + OC_W'(1);
   end
endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen
   import baud_gen_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned PSC_W       = 5,
   parameter int unsigned DIV_W       = 11,
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tx_src_ext,
   input  logic              rx_src_ext,
   input  logic              ext_clk_in,
   output logic              tx_x16_en,
   output logic              rx_x16_en,
   output logic              tx_bit_en,
   output logic              rx_bit_en
);
   localparam int unsigned HI_W = DIV_W - DATA_W;

   if (DIV_W <= DATA_W) begin : g_bad_div
      $error("DIV_W must exceed DATA_W");
   end
   if (HI_W + PSC_W != DATA_W) begin : g_bad_split
      $error("prescaler code and divisor upper bits must fill one register");
   end
   if (OVS < 2 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("OVS must be a power of two, at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [DATA_W-1:0] psc_reg;
   logic [DATA_W-1:0] baud_reg;
   logic              reload_q;
   logic [PSC_W-1:0]  psc_code;
   logic [DIV_W-1:0]  div_val;
   logic              run;
   logic              psc_tick;
   logic              int_x16;
   logic              ext_tick;
   logic [CHAN_N-1:0] use_ext;
   logic [CHAN_N-1:0] ch_x16;
   logic [CHAN_N-1:0] ch_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_reg  <= '0;
         baud_reg <= '0;
         reload_q <= 1'b0;
      end else begin
         reload_q <= reg_wr;
         if (reg_wr && reg_addr == ADDR_PSC)  psc_reg  <= reg_wdata;
         if (reg_wr && reg_addr == ADDR_BAUD) baud_reg <= reg_wdata;
      end
   end

   assign reg_rdata = (reg_addr == ADDR_PSC) ? psc_reg : baud_reg;
   assign psc_code  = psc_reg[DATA_W-1 -: PSC_W];
   assign div_val   = {psc_reg[HI_W-1:0], baud_reg};
   assign run       = (psc_code != '0);

   baud_psc_frac #(.PSC_W(PSC_W)) i_psc (
      .clk(clk), .rst_n(rst_n), .reload(reload_q), .code(psc_code), .tick(psc_tick)
   );

   baud_div_cnt #(.DIV_W(DIV_W)) i_div (
      .clk(clk), .rst_n(rst_n), .reload(reload_q), .div(div_val),
      .in_tick(psc_tick), .out_tick(int_x16)
   );

   baud_ext_sync #(.STAGES(SYNC_STAGES)) i_ext (
      .clk(clk), .rst_n(rst_n), .pin(ext_clk_in), .rise(ext_tick)
   );

   assign use_ext[CHAN_TX] = tx_src_ext;
   assign use_ext[CHAN_RX] = rx_src_ext;

   for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
      baud_chan_sel #(.OVS(OVS)) i_chan (
         .clk(clk), .rst_n(rst_n), .reload(reload_q), .run(run),
         .use_ext(use_ext[c]), .int_tick(int_x16), .ext_tick(ext_tick),
         .x16_en(ch_x16[c]), .bit_en(ch_bit[c])
      );
   end

   assign tx_x16_en = ch_x16[CHAN_TX];
   assign rx_x16_en = ch_x16[CHAN_RX];
   assign tx_bit_en = ch_bit[CHAN_TX];
   assign rx_bit_en = ch_bit[CHAN_RX];
endmodule

// File: rtl/baud_clk_gen_chk.sv
module baud_clk_gen_chk #(
   parameter int unsigned PSC_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [PSC_W-1:0] psc_code,
   input logic             psc_tick,
   input logic             int_x16,
   input logic             ext_tick,
   input logic             tx_x16_en,
   input logic             rx_x16_en,
   input logic             tx_bit_en,
   input logic             rx_bit_en
);
   // R3
   pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psc_code == '0) |-> !(tx_x16_en || rx_x16_en || tx_bit_en || rx_bit_en));

   // R6
   bit_in_x16_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_bit_en |-> tx_x16_en) and (rx_bit_en |-> rx_x16_en));

   // R6
   bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_bit_en |=> !tx_bit_en) and (rx_bit_en |=> !rx_bit_en));

   // R8
   reload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> ##1 !int_x16);

   // R1
   psc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psc_tick && psc_code >= PSC_W'(3)) |=> !psc_tick);

   // R7
   ext_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_tick |=> !ext_tick);
endmodule

bind baud_clk_gen baud_clk_gen_chk #(.PSC_W(PSC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .psc_code(psc_code),
   .psc_tick(psc_tick), .int_x16(int_x16), .ext_tick(ext_tick),
   .tx_x16_en(tx_x16_en), .rx_x16_en(rx_x16_en),
   .tx_bit_en(tx_bit_en), .rx_bit_en(rx_bit_en)
);

// File: tb/test_baud_clk_gen.sv
module test_baud_clk_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       tx_src_ext = 1'b0;
   logic       rx_src_ext = 1'b0;
   logic       ext_clk_in = 1'b0;
   logic       tx_x16_en, rx_x16_en, tx_bit_en, rx_bit_en;
   logic       ext_run = 1'b0;

   int cyc = 0;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   baud_clk_gen i_baud_clk_gen (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_src_ext(tx_src_ext), .rx_src_ext(rx_src_ext), .ext_clk_in(ext_clk_in),
      .tx_x16_en(tx_x16_en), .rx_x16_en(rx_x16_en),
      .tx_bit_en(tx_bit_en), .rx_bit_en(rx_bit_en)
   );

   initial begin
      forever begin
         @(negedge clk);
         if (ext_run) begin
            repeat (3) @(negedge clk);
            ext_clk_in = ~ext_clk_in;
         end else begin
            ext_clk_in = 1'b0;
         end
      end
   end

   function automatic int gap_x16(int s, int d);
      return (d + 1) * (s + 1);
   endfunction

   function automatic int gap_bit(int s, int d);
      return 8 * (d + 1) * (s + 1);
   endfunction

   function automatic int first_lat(int s, int d);
      return 2 + ((d + 1) * (s + 1) + 1) / 2;
   endfunction

   function automatic logic pick(int sel);
      case (sel)
         0: return tx_x16_en;
         1: return rx_x16_en;
         2: return tx_bit_en;
         default: return rx_bit_en;
      endcase
   endfunction

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(logic a, logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic set_rate(int s, int d);
      wr(1'b0, 8'((s << 3) | ((d >> 8) & 7)));
      wr(1'b1, 8'(d & 255));
   endtask

   task automatic next_pulse(int sel, output int t);
      int w = 0;
      t = -1;
      do begin
         @(negedge clk);
         w++;
      end while (!pick(sel) && w < 40000);
      if (pick(sel)) t = cyc;
   endtask

   task automatic span(int sel, int n, output int dt);
      int t0, t1;
      next_pulse(sel, t0);
      t1 = t0;
      for (int k = 0; k < n; k++) next_pulse(sel, t1);
      dt = (t0 < 0 || t1 < 0) ? -1 : t1 - t0;
   endtask

   task automatic rate_case(string tag, int s, int d, bit do_bit);
      int dt;
      set_rate(s, d);
      span(0, 2, dt);
      check({tag, " R1 R2 tx x16 span"}, dt, gap_x16(s, d));
      span(1, 2, dt);
      check({tag, " R2 rx x16 span"}, dt, gap_x16(s, d));
      if (do_bit) begin
         span(3, 1, dt);
         check({tag, " R6 rx bit gap"}, dt, gap_bit(s, d));
      end
   endtask

   initial begin
      int dt, c0, t, hits, s, d;
      void'($urandom(32'h5eed_0b1d));
      repeat (3) @(negedge clk);
      hits = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (tx_x16_en || rx_x16_en || tx_bit_en || rx_bit_en) hits++;
      end
      check("R5 enables in reset", hits, 0);
      rst_n = 1'b1;
      hits = 0;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (tx_x16_en || rx_x16_en || tx_bit_en || rx_bit_en) hits++;
      end
      check("R5 R3 enables after reset", hits, 0);
      reg_addr = 1'b0; #1;
      check("R5 prescaler reg reset", int'(reg_rdata), 0);
      reg_addr = 1'b1; #1;
      check("R5 baud reg reset", int'(reg_rdata), 0);

      wr(1'b0, 8'hAB);
      wr(1'b1, 8'h5C);
      reg_addr = 1'b0; #1;
      check("R4 readback addr0", int'(reg_rdata), 'hAB);
      reg_addr = 1'b1; #1;
      check("R4 readback addr1", int'(reg_rdata), 'h5C);

      rate_case("s1d0", 1, 0, 1'b1);
      rate_case("s2d0", 2, 0, 1'b1);
      rate_case("s31d3", 31, 3, 1'b1);
      rate_case("s1dmax", 1, 2047, 1'b0);
      rate_case("s2d256", 2, 256, 1'b0);

      for (int i = 0; i < 10; i++) begin
         s = 1 + int'($urandom_range(30));
         d = int'($urandom_range(15));
         rate_case($sformatf("rnd%0d", i), s, d, 1'b1);
      end

      // R8: time first enable after a mid-period rewrite
      set_rate(5, 9);
      repeat (7) @(negedge clk);
      wr(1'b1, 8'd6);
      c0 = cyc;
      next_pulse(0, t);
      check("R8 first x16 latency", t - c0, first_lat(5, 6));
      set_rate(4, 2);
      c0 = cyc;
      next_pulse(1, t);
      check("R8 first x16 latency s4", t - c0, first_lat(4, 2));

      // R7: tx from external pin, rx internal
      set_rate(3, 2);
      tx_src_ext = 1'b1;
      ext_run = 1'b1;
      repeat (20) @(negedge clk);
      span(0, 2, dt);
      check("R7 tx ext x16 span", dt, 16);
      span(2, 1, dt);
      check("R7 R6 tx ext bit gap", dt, 128);
      span(1, 2, dt);
      check("R7 rx stays internal", dt, gap_x16(3, 2));

      // R3: power-down with pin still toggling
      wr(1'b0, 8'h00);
      hits = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (tx_x16_en || rx_x16_en || tx_bit_en || rx_bit_en) hits++;
      end
      check("R3 power-down silent", hits, 0);
      ext_run = 1'b0;
      tx_src_ext = 1'b0;

      rx_src_ext = 1'b1;
      ext_run = 1'b1;
      set_rate(2, 1);
      repeat (20) @(negedge clk);
      span(1, 2, dt);
      check("R7 rx ext x16 span", dt, 16);
      span(0, 2, dt);
      check("R7 tx stays internal", dt, gap_x16(2, 1));

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule